// File: doc/BRIEF.md
# Dual-Register Configurable Logic Cell

This block models one output cell of a sum-of-products programmable logic device. Two flip-flops sit in the cell, and each takes its own sum-term input. Each flip-flop is configured on its own as a data-type or toggle-type register and clocks from either its private term clock or the shared pin clock. Both register outputs always return to the array through `regFb`. Register 0 can also reach the pin. Per-register asynchronous clears, a device-wide synchronous set and an active-low power-on clear control the register state.

The pin side is split into `pinOut`, `pinOe` and `pinFb`, as it would be inside a larger chip. The output path selects either the combinational sum of register 0 or its stored value, then applies a programmable inversion. A per-cell enable term gates the driver. The pin input level stays visible on `pinFb` at all times. In test preload mode the driver is released and a clock edge writes the externally applied pin level into the register picked by `preloadSel`. The configuration inputs are treated as static strap values.

Top module: `plcDualRegCell`

## Requirements
- R1: With `cfgTType[g]`=0, an active clock edge of register g loads `sumIn[g]`.
- R2: With `cfgTType[g]`=1, an active clock edge of register g inverts it when `sumIn[g]`=1 and holds it when `sumIn[g]`=0.
- R3: Register g clocks on rising `pinClk` when `cfgPinClk[g]`=1 and on rising `ptClk[g]` when `cfgPinClk[g]`=0. Edges on the unselected source leave it unchanged.
- R4: A high `asyncRst[g]` clears register g at once, without a clock, and holds it low against every other input. The other register is unaffected.
- R5: A low `porN` clears both registers at once. After the clear, `pinOut` in registered mode equals `cfgInvert`.
- R6: A high `syncPreset` at a register's active edge sets that register to 1. It takes precedence over the data and toggle updates.
- R7: With `preloadMode`=1, an active edge loads `pinIn` into register 0 when `preloadSel`=0 and into register 1 when `preloadSel`=1. The other register holds. The loaded value ignores `cfgInvert`, and preload takes precedence over `syncPreset`.
- R8: `pinOut` equals `regFb[0]` XOR `cfgInvert` when `cfgRegOut`=1, and `sumIn[0]` XOR `cfgInvert` when `cfgRegOut`=0.
- R9: `pinOe` follows `oeTerm` outside preload and is 0 during preload. `pinFb` always equals `pinIn`.
- R10: `regFb[g]` always shows the current state of register g, for both registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pinClk | input | 1 | Shared dedicated clock pin |
| porN | input | 1 | Active-low power-on clear of both registers |
| ptClk | input | 2 | Per-register term clock |
| sumIn | input | 2 | Per-register sum-term data |
| asyncRst | input | 2 | Per-register asynchronous clear, active high |
| syncPreset | input | 1 | Device-wide synchronous set |
| oeTerm | input | 1 | Cell output-enable term |
| preloadMode | input | 1 | Test preload mode |
| preloadSel | input | 1 | Preload target register index |
| pinIn | input | 1 | Level present on the I/O pin |
| cfgTType | input | 2 | Per-register toggle-type select |
| cfgPinClk | input | 2 | Per-register clock source: 1 selects the pin clock |
| cfgRegOut | input | 1 | 1 selects the registered output, 0 the combinational output |
| cfgInvert | input | 1 | Output inversion |
| regFb | output | 2 | Register states fed back to the array |
| pinOut | output | 1 | Pin drive data |
| pinOe | output | 1 | Pin driver enable |
| pinFb | output | 1 | Pin input path to the array |

## Verification
The bench runs the two registers from different clock sources at the same time. It pulses the term clock of a register that is set to the pin clock, so a clock mux that ignores its select would show up as a wrong register state. It raises preload together with the synchronous set and with an asynchronous clear, so a wrong priority order would leave a 1 where a 0 or the pin level is expected. Preload runs with inversion enabled, and both index values are checked for a hold on the unselected register, which catches a loaded value that was inverted or a preload written into both registers. A clear raised in the middle of a cycle is checked before the next clock edge, so a clear that waits for a clock is caught.

// File: rtl/plcCellPkg.sv
package plcCellPkg;
  parameter int CELL_REGS = 2;
  localparam int SEL_W = (CELL_REGS > 1) ? $clog2(CELL_REGS) : 1;

  typedef struct packed {
    logic [CELL_REGS-1:0] loadPin;
    logic [CELL_REGS-1:0] holdQ;
    logic [CELL_REGS-1:0] loadOne;
    logic                 drivePin;
  } cellStrobes_t;
endpackage

// File: rtl/plcCellCtrl.sv
module plcCellCtrl
  import plcCellPkg::*;
(
  input  logic             preloadMode,
  input  logic [SEL_W-1:0] preloadSel,
  input  logic             syncPreset,
  input  logic             oeTerm,
  output cellStrobes_t     strobes
);
  for (genvar g = 0; g < CELL_REGS; g++) begin : gSel
    logic picked;
    assign picked = preloadMode && (preloadSel == SEL_W'(g));
    assign strobes.loadPin[g] = picked;
    assign strobes.holdQ[g]   = preloadMode && !picked;
    assign strobes.loadOne[g] = !preloadMode && syncPreset;
  end
  assign strobes.drivePin = oeTerm && !preloadMode;
endmodule

// File: rtl/plcCellDatapath.sv
module plcCellDatapath
  import plcCellPkg::*;
(
  input  logic                 pinClk,
  input  logic                 porN,
  input  logic [CELL_REGS-1:0] ptClk,
  input  logic [CELL_REGS-1:0] sumIn,
  input  logic [CELL_REGS-1:0] asyncRst,
  input  logic                 pinIn,
  input  logic [CELL_REGS-1:0] cfgTType,
  input  logic [CELL_REGS-1:0] cfgPinClk,
  input  logic                 cfgRegOut,
  input  logic                 cfgInvert,
  input  cellStrobes_t         strobes,
  output logic [CELL_REGS-1:0] regFb,
  output logic                 pinOut,
  output logic                 pinOe
);
  for (genvar g = 0; g < CELL_REGS; g++) begin : gReg
    logic cellClk;
    logic cellClr;
    logic q;
    assign cellClk = cfgPinClk[g] ? pinClk : ptClk[g];
    assign cellClr = asyncRst[g] || !porN;
    always_ff @(posedge cellClk or posedge cellClr) begin
      if (cellClr)                 q <= 1'b0;
      else if (strobes.holdQ[g])   q <= q;
      else if (strobes.loadPin[g]) q <= pinIn;
      else if (strobes.loadOne[g]) q <= 1'b1;
      else if (cfgTType[g])        q <= q ^ sumIn[g];
      else                         q <= sumIn[g];
    end
    assign regFb[g] = q;
  end

  logic outSel;
  assign outSel = cfgRegOut ? regFb[0] : sumIn[0];
  assign pinOut = outSel ^ cfgInvert;
  assign pinOe  = strobes.drivePin;
endmodule

// File: rtl/plcDualRegCell.sv
module plcDualRegCell
  import plcCellPkg::*;
(
  input  logic                 pinClk,
  input  logic                 porN,
  input  logic [CELL_REGS-1:0] ptClk,
  input  logic [CELL_REGS-1:0] sumIn,
  input  logic [CELL_REGS-1:0] asyncRst,
  input  logic                 syncPreset,
  input  logic                 oeTerm,
  input  logic                 preloadMode,
  input  logic [SEL_W-1:0]     preloadSel,
  input  logic                 pinIn,
  input  logic [CELL_REGS-1:0] cfgTType,
  input  logic [CELL_REGS-1:0] cfgPinClk,
  input  logic                 cfgRegOut,
  input  logic                 cfgInvert,
  output logic [CELL_REGS-1:0] regFb,
  output logic                 pinOut,
  output logic                 pinOe,
  output logic                 pinFb
);
  cellStrobes_t strobes;

  plcCellCtrl uCtrl (
    .preloadMode(preloadMode), .preloadSel(preloadSel),
    .syncPreset(syncPreset), .oeTerm(oeTerm), .strobes(strobes)
  );

  plcCellDatapath uData (
    .pinClk(pinClk), .porN(porN), .ptClk(ptClk), .sumIn(sumIn),
    .asyncRst(asyncRst), .pinIn(pinIn), .cfgTType(cfgTType),
    .cfgPinClk(cfgPinClk), .cfgRegOut(cfgRegOut), .cfgInvert(cfgInvert),
    .strobes(strobes), .regFb(regFb), .pinOut(pinOut), .pinOe(pinOe)
  );

  assign pinFb = pinIn;
endmodule

// File: rtl/plcDualRegCellChk.sv
module plcDualRegCellChk
  import plcCellPkg::*;
(
  input logic                 pinClk,
  input logic                 porN,
  input logic [CELL_REGS-1:0] sumIn,
  input logic [CELL_REGS-1:0] asyncRst,
  input logic                 syncPreset,
  input logic                 preloadMode,
  input logic [SEL_W-1:0]     preloadSel,
  input logic                 pinIn,
  input logic [CELL_REGS-1:0] cfgTType,
  input logic [CELL_REGS-1:0] cfgPinClk,
  input logic                 cfgRegOut,
  input logic                 cfgInvert,
  input logic [CELL_REGS-1:0] regFb,
  input logic                 pinOut,
  input logic                 pinOe
);
  AST_POR_CLEAR: assert property (@(posedge pinClk)
    !porN |=> (porN || regFb == '0)); // R5

  AST_REG_OUT_PATH: assert property (@(posedge pinClk) disable iff (!porN)
    cfgRegOut |-> (pinOut == (regFb[0] ^ cfgInvert))); // R8

  AST_PRELOAD_NO_DRIVE: assert property (@(posedge pinClk) disable iff (!porN)
    preloadMode |-> !pinOe); // R9

  for (genvar g = 0; g < CELL_REGS; g++) begin : gChk
    AST_CLEAR_HOLDS: assert property (@(posedge pinClk) disable iff (!porN)
      asyncRst[g] |=> (!asyncRst[g] || !regFb[g])); // R4

    AST_D_UPDATE: assert property (@(posedge pinClk) disable iff (!porN)
      (cfgPinClk[g] && !cfgTType[g] && !preloadMode && !syncPreset && !asyncRst[g])
      |=> (asyncRst[g] || regFb[g] == $past(sumIn[g]))); // R1

    AST_T_UPDATE: assert property (@(posedge pinClk) disable iff (!porN)
      (cfgPinClk[g] && cfgTType[g] && !preloadMode && !syncPreset && !asyncRst[g])
      |=> (asyncRst[g] || regFb[g] == ($past(regFb[g]) ^ $past(sumIn[g])))); // R2

    AST_PRESET_SETS: assert property (@(posedge pinClk) disable iff (!porN)
      (cfgPinClk[g] && syncPreset && !preloadMode && !asyncRst[g])
      |=> (asyncRst[g] || regFb[g])); // R6

    AST_PRELOAD_STEER: assert property (@(posedge pinClk) disable iff (!porN)
      (cfgPinClk[g] && preloadMode && !asyncRst[g])
      |=> (asyncRst[g] || regFb[g] == (($past(preloadSel) == SEL_W'(g)) ?
                                        $past(pinIn) : $past(regFb[g])))); // R7
  end
endmodule

bind plcDualRegCell plcDualRegCellChk uChk (
  .pinClk(pinClk), .porN(porN), .sumIn(sumIn), .asyncRst(asyncRst),
  .syncPreset(syncPreset), .preloadMode(preloadMode), .preloadSel(preloadSel),
  .pinIn(pinIn), .cfgTType(cfgTType), .cfgPinClk(cfgPinClk),
  .cfgRegOut(cfgRegOut), .cfgInvert(cfgInvert), .regFb(regFb),
  .pinOut(pinOut), .pinOe(pinOe)
);

// File: tb/tb_plcDualRegCell.sv
`timescale 1ns/1ps
module tb_plcDualRegCell;
  logic       clk = 1'b0;
  logic       porN = 1'b0;
  logic [1:0] ptClk = '0, sumIn = '0, asyncRst = '0, cfgTType = '0, cfgPinClk = 2'b11;
  logic       syncPreset = 0, oeTerm = 1, preloadMode = 0, pinIn = 0;
  logic [0:0] preloadSel = '0;
  logic       cfgRegOut = 1, cfgInvert = 0;
  logic [1:0] regFb;
  logic       pinOut, pinOe, pinFb;

  int checks = 0, failures = 0;
  bit done = 0;
  string curReq = "R10";
  bit m [2];
  logic [1:0] pre;

  always #5 clk = ~clk;

  plcDualRegCell dut (
    .pinClk(clk), .porN(porN), .ptClk(ptClk), .sumIn(sumIn), .asyncRst(asyncRst),
    .syncPreset(syncPreset), .oeTerm(oeTerm), .preloadMode(preloadMode),
    .preloadSel(preloadSel), .pinIn(pinIn), .cfgTType(cfgTType),
    .cfgPinClk(cfgPinClk), .cfgRegOut(cfgRegOut), .cfgInvert(cfgInvert),
    .regFb(regFb), .pinOut(pinOut), .pinOe(pinOe), .pinFb(pinFb)
  );

  // behavioural reference model
  task automatic mStep(input int g);
    if (asyncRst[g] || !porN) m[g] = 0;
    else if (preloadMode) begin
      if (int'(preloadSel) == g) m[g] = pinIn;
    end
    else if (syncPreset) m[g] = 1;
    else if (cfgTType[g]) m[g] = m[g] ^ sumIn[g];
    else m[g] = sumIn[g];
  endtask

  always @(posedge clk) for (int g = 0; g < 2; g++) if (cfgPinClk[g]) mStep(g);
  always @(posedge ptClk[0]) if (!cfgPinClk[0]) mStep(0);
  always @(posedge ptClk[1]) if (!cfgPinClk[1]) mStep(1);
  always @(asyncRst or porN) for (int g = 0; g < 2; g++) if (asyncRst[g] || !porN) m[g] = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #4;
    if (!done) begin
      logic [1:0] expFb;
      logic expOut;
      expFb  = {m[1], m[0]};
      expOut = (cfgRegOut ? m[0] : sumIn[0]) ^ cfgInvert;
      chk(regFb == expFb, curReq, regFb, expFb);
      chk(pinOut == expOut, "R8", pinOut, expOut);
      chk(pinOe == (oeTerm && !preloadMode), "R9", pinOe, oeTerm && !preloadMode);
      chk(pinFb == pinIn, "R9", pinFb, pinIn);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // called at +1: pulse a term clock in the second half of the cycle
  task automatic ptPulse(input int g);
    #5 ptClk[g] = 1'b1;
    #2 ptClk[g] = 1'b0;
  endtask

  // called at +1: move clock-source select while both clocks are low
  task automatic setClkSrc(input logic [1:0] src);
    #6 cfgPinClk = src;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(2);
    curReq = "R5";
    chk(regFb == 2'b00, "R5", regFb, 0);
    chk(pinOut == 1'b0, "R5", pinOut, 0);
    porN = 1;

    // R1 data type, both on pin clock
    curReq = "R1";
    for (int i = 0; i < 6; i++) begin sumIn = 2'(i * 3 + 1); step(1); end
    sumIn = 2'b10; step(1);
    chk(regFb == 2'b10, "R1", regFb, 2);

    // R2 toggle type
    curReq = "R2";
    cfgTType = 2'b11;
    sumIn = 2'b11; step(3);
    pre = regFb; sumIn = 2'b01; step(1);
    chk(regFb == {pre[1], ~pre[0]}, "R2", regFb, {pre[1], ~pre[0]});
    pre = regFb; sumIn = 2'b00; step(1);
    chk(regFb == pre, "R2", regFb, pre);

    // R3 independent clock sources
    curReq = "R3";
    cfgTType = 2'b00;
    setClkSrc(2'b01); step(1);
    sumIn = 2'b00; ptPulse(1); #1;
    chk(regFb[1] == 1'b0, "R3", regFb[1], 0);
    step(1);
    sumIn = 2'b11; step(3);
    chk(regFb == 2'b01, "R3", regFb, 1);
    ptPulse(0); #1;
    chk(regFb == 2'b01, "R3", regFb, 1);
    ptPulse(1); #1;
    chk(regFb == 2'b11, "R3", regFb, 3);
    step(1);

    // R4 asynchronous clear, only the addressed register
    curReq = "R4";
    asyncRst = 2'b10; #1;
    chk(regFb == 2'b01, "R4", regFb, 1);
    ptPulse(1); #1;
    chk(regFb[1] == 1'b0, "R4", regFb[1], 0);
    step(1);
    asyncRst = 2'b00;
    setClkSrc(2'b11); step(1);
    preloadMode = 1; preloadSel = 1'b0; pinIn = 1; asyncRst = 2'b01; step(1);
    chk(regFb[0] == 1'b0, "R4", regFb[0], 0);
    preloadMode = 0; asyncRst = 2'b00; pinIn = 0;

    // R6 synchronous set beats data
    curReq = "R6";
    sumIn = 2'b00; syncPreset = 1; step(1);
    chk(regFb == 2'b11, "R6", regFb, 3);
    syncPreset = 0; step(1);
    chk(regFb == 2'b00, "R6", regFb, 0);

    // R7 preload steering, inversion on, set also asserted
    curReq = "R7";
    cfgInvert = 1; preloadMode = 1; syncPreset = 1;
    preloadSel = 1'b0; pinIn = 1; step(1);
    chk(regFb == 2'b01, "R7", regFb, 1);
    chk(pinOe == 1'b0, "R9", pinOe, 0);
    preloadSel = 1'b1; pinIn = 1; step(1);
    chk(regFb == 2'b11, "R7", regFb, 3);
    preloadSel = 1'b0; pinIn = 0; step(1);
    chk(regFb == 2'b10, "R7", regFb, 2);
    preloadMode = 0; syncPreset = 0; sumIn = 2'b01; step(1);

    // R8 output selection and polarity
    curReq = "R8";
    cfgRegOut = 0; sumIn = 2'b01; #1;
    chk(pinOut == 1'b0, "R8", pinOut, 0);
    cfgInvert = 0; #1;
    chk(pinOut == 1'b1, "R8", pinOut, 1);
    step(1);
    cfgRegOut = 1; sumIn = 2'b00; step(1);
    chk(pinOut == 1'b0, "R8", pinOut, 0);

    // R9 enable and input path
    curReq = "R9";
    oeTerm = 0; pinIn = 1; #1;
    chk(pinOe == 1'b0, "R9", pinOe, 0);
    chk(pinFb == 1'b1, "R9", pinFb, 1);
    step(1);
    oeTerm = 1; step(1);

    // R5 power-on clear mid-run
    curReq = "R5";
    sumIn = 2'b11; step(1);
    cfgInvert = 1; porN = 0; #1;
    chk(regFb == 2'b00, "R5", regFb, 0);
    chk(pinOut == 1'b1, "R5", pinOut, 1);
    step(2);
    porN = 1; step(2);
    curReq = "R10";
    chk(regFb == 2'b11, "R10", regFb, 3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule